// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the status and control word for one host root port. A single 32-bit word is written and read over a plain register bus. A write carries the whole word whenever `wr_en` is high. A read returns the current word combinationally. Live link-side inputs feed the connect, over-current, speed and link-state fields directly. The block itself stores the port-enable, port-reset, warm-reset, cold-attach, power, indicator and wake-enable bits, along with seven sticky change flags that software clears by writing one.

Link-side pulses report the following events:
- reset completion
- warm-reset completion
- cold attach
- configuration failure

The block drives a port-reset request, a warm-reset request, a one-cycle link-state change request with its target state, and an interrupt line. The interrupt line is high while any change flag is set. A small tracker watches the reported link state and raises the link-change flag on the transitions listed below.

Top module: `usb_root_port_regs`

## Requirements
- R1: After reset every stored bit is zero. Bit 0 reads `hw_connect`, bit 3 reads `hw_overcurrent`, bits 8:5 read `hw_link_state` and bits 13:10 read `hw_speed`. Bits 2, 16, 28, 29 and 30 always read zero.
- R2: Every write loads power (bit 9), indicator (bits 15:14) and the three wake enables (bits 27:25) from the written word, and these bits read back as written.
- R3: A write with bit 16 set drives `link_wr_req` high for exactly the next cycle, with `link_wr_state` equal to the written bits 8:5. A write with bit 16 clear raises no request, and bits 8:5 keep reading the link input.
- R4: Change flags occupy bits 23:17. Writing 1 to a flag clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag set.
- R5: `irq` is high exactly when at least one change flag is set.
- R6: Connect change (bit 17) sets on any change of `hw_connect`. Over-current change (bit 20) sets on any change of `hw_overcurrent`.
- R7: Writing 1 to bit 4 sets the reset bit and `port_reset_req`. A `hw_reset_done` pulse while the reset bit is set clears it, sets reset change (bit 21), and enables the port (bit 1) if a device is connected.
- R8: Writing 1 to bit 1 while the port is enabled disables it and sets enable change (bit 18). Writing 1 to bit 1 while disabled has no effect. Disconnect clears bit 1 without setting bit 18.
- R9: Writing 1 to bit 31 sets it and `warm_reset_req`. A `hw_warm_done` pulse while bit 31 is set clears it, sets warm-reset change (bit 19) and clears cold-attach status (bit 24). `hw_cold_attach` sets bit 24.
- R10: Link codes are U0=0, U2=2, U3=3, Inactive=6, Recovery=8 and Resume=0xF. Link change (bit 22) sets when the reported link state changes in any of these ways:
  - U3 to Resume
  - Resume to U0
  - U3 to U0
  - U2 to U0
  - Recovery to U0, but only when Recovery was entered from U3 or Resume
  - any state to Inactive
- R11: A `hw_cfg_err` pulse sets config-error change (bit 23).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| hw_connect | input | 1 | Device present |
| hw_overcurrent | input | 1 | Over-current condition |
| hw_speed | input | 4 | Attached device speed code |
| hw_link_state | input | 4 | Reported link state code |
| hw_reset_done | input | 1 | Port reset finished (pulse) |
| hw_warm_done | input | 1 | Warm reset finished (pulse) |
| hw_cold_attach | input | 1 | Attach seen while asleep (pulse) |
| hw_cfg_err | input | 1 | Link partner configuration failed (pulse) |
| port_reset_req | output | 1 | Port reset requested |
| warm_reset_req | output | 1 | Warm reset requested |
| link_wr_req | output | 1 | One-cycle link state change request |
| link_wr_state | output | 4 | Requested link state |
| irq | output | 1 | Some change flag is set |

## Verification
The assertions assume the following about the link side:
- Completion pulses last one cycle.
- `hw_link_state` changes at most once per clock, so the tracker sees every intermediate state of a path such as U3 to Recovery to U0.

The bench drives every link input on the falling edge and holds it across at least one rising edge, so each step of a transition path is sampled. It pulses completion signals only while the matching request is pending, except where a check deliberately exercises an ignored event.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int LS_W   = 4;
  localparam int SPD_W  = 4;
  localparam int N_CHG  = 7;

  localparam int B_CONN  = 0;
  localparam int B_EN    = 1;
  localparam int B_OC    = 3;
  localparam int B_RST   = 4;
  localparam int B_LS    = 5;
  localparam int B_PWR   = 9;
  localparam int B_SPD   = 10;
  localparam int B_IND   = 14;
  localparam int B_STRB  = 16;
  localparam int B_CHG   = 17;
  localparam int B_CAS   = 24;
  localparam int B_WAKE  = 25;
  localparam int B_WARM  = 31;

  localparam int C_CONN = 0;
  localparam int C_EN   = 1;
  localparam int C_WARM = 2;
  localparam int C_OC   = 3;
  localparam int C_RST  = 4;
  localparam int C_LINK = 5;
  localparam int C_CFG  = 6;

  localparam logic [LS_W-1:0] LS_U0       = 4'h0;
  localparam logic [LS_W-1:0] LS_U2       = 4'h2;
  localparam logic [LS_W-1:0] LS_U3       = 4'h3;
  localparam logic [LS_W-1:0] LS_RXDET    = 4'h5;
  localparam logic [LS_W-1:0] LS_INACTIVE = 4'h6;
  localparam logic [LS_W-1:0] LS_RECOVERY = 4'h8;
  localparam logic [LS_W-1:0] LS_RESUME   = 4'hF;
endpackage

// File: rtl/rp_link_track.sv
module rp_link_track
  import rp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LS_W-1:0] ls_i,
  output logic            plc_o
);
  logic [LS_W-1:0] prev_q;
  logic            via_q, via_d;

  always_comb begin
    plc_o = 1'b0;
    via_d = via_q;
    if (ls_i != prev_q) begin
      if (prev_q == LS_U3 && ls_i == LS_RESUME) plc_o = 1'b1;
      if (prev_q == LS_RESUME && ls_i == LS_U0) plc_o = 1'b1;
      if (prev_q == LS_U3 && ls_i == LS_U0) plc_o = 1'b1;
      if (prev_q == LS_U2 && ls_i == LS_U0) plc_o = 1'b1;
      if (prev_q == LS_RECOVERY && ls_i == LS_U0 && via_q) plc_o = 1'b1;
      if (ls_i == LS_INACTIVE) plc_o = 1'b1;
      via_d = (ls_i == LS_RECOVERY) && (prev_q == LS_U3 || prev_q == LS_RESUME);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LS_RXDET;
      via_q  <= 1'b0;
    end else begin
      prev_q <= ls_i;
      via_q  <= via_d;
    end
  end

  assert_plc_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    plc_o |-> (ls_i == LS_U0 || ls_i == LS_RESUME || ls_i == LS_INACTIVE));
endmodule

// File: rtl/rp_change_flags.sv
module rp_change_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic         any_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
  assign any_o  = |flag_q;
endmodule

// File: rtl/usb_root_port_regs.sv
module usb_root_port_regs
  import rp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        hw_connect,
  input  logic        hw_overcurrent,
  input  logic [3:0]  hw_speed,
  input  logic [3:0]  hw_link_state,
  input  logic        hw_reset_done,
  input  logic        hw_warm_done,
  input  logic        hw_cold_attach,
  input  logic        hw_cfg_err,
  output logic        port_reset_req,
  output logic        warm_reset_req,
  output logic        link_wr_req,
  output logic [3:0]  link_wr_state,
  output logic        irq
);
  logic en_q, en_d, rst_q, rst_d, warm_q, warm_d, cas_q, cas_d;
  logic pwr_q, pwr_d;
  logic [1:0] ind_q, ind_d;
  logic [2:0] wake_q, wake_d;
  logic lwr_q, lwr_d;
  logic [LS_W-1:0] lst_q, lst_d;
  logic conn_q, oc_q;
  logic plc;
  logic rst_fin, warm_fin;
  logic [N_CHG-1:0] chg_set, chg_clr, chg;

  rp_link_track u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .ls_i  (hw_link_state),
    .plc_o (plc)
  );

  always_comb begin
    rst_fin  = rst_q && hw_reset_done;
    warm_fin = warm_q && hw_warm_done;

    rst_d = rst_q;
    if (wr_en && wr_data[B_RST]) rst_d = 1'b1;
    if (rst_fin) rst_d = 1'b0;

    warm_d = warm_q;
    if (wr_en && wr_data[B_WARM]) warm_d = 1'b1;
    if (warm_fin) warm_d = 1'b0;

    cas_d = cas_q;
    if (hw_cold_attach) cas_d = 1'b1;
    if (warm_fin) cas_d = 1'b0;

    en_d = en_q;
    if (wr_en && wr_data[B_EN]) en_d = 1'b0;
    if (rst_fin) en_d = 1'b1;
    if (!hw_connect) en_d = 1'b0;

    pwr_d  = wr_en ? wr_data[B_PWR] : pwr_q;
    ind_d  = wr_en ? wr_data[B_IND +: 2] : ind_q;
    wake_d = wr_en ? wr_data[B_WAKE +: 3] : wake_q;

    lwr_d = wr_en && wr_data[B_STRB];
    lst_d = lwr_d ? wr_data[B_LS +: LS_W] : lst_q;

    chg_set         = '0;
    chg_set[C_CONN] = hw_connect ^ conn_q;
    chg_set[C_EN]   = en_q && wr_en && wr_data[B_EN];
    chg_set[C_WARM] = warm_fin;
    chg_set[C_OC]   = hw_overcurrent ^ oc_q;
    chg_set[C_RST]  = rst_fin;
    chg_set[C_LINK] = plc;
    chg_set[C_CFG]  = hw_cfg_err;
    chg_clr = wr_en ? wr_data[B_CHG +: N_CHG] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rst_q  <= 1'b0;
      warm_q <= 1'b0;
      cas_q  <= 1'b0;
      pwr_q  <= 1'b0;
      ind_q  <= '0;
      wake_q <= '0;
      lwr_q  <= 1'b0;
      lst_q  <= '0;
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      rst_q  <= rst_d;
      warm_q <= warm_d;
      cas_q  <= cas_d;
      pwr_q  <= pwr_d;
      ind_q  <= ind_d;
      wake_q <= wake_d;
      lwr_q  <= lwr_d;
      lst_q  <= lst_d;
      conn_q <= hw_connect;
      oc_q   <= hw_overcurrent;
    end
  end

  rp_change_flags #(.N(N_CHG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .flag_o (chg),
    .any_o  (irq)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[B_CONN]           = hw_connect;
    rd_data[B_EN]             = en_q;
    rd_data[B_OC]             = hw_overcurrent;
    rd_data[B_RST]            = rst_q;
    rd_data[B_LS +: LS_W]     = hw_link_state;
    rd_data[B_PWR]            = pwr_q;
    rd_data[B_SPD +: SPD_W]   = hw_speed;
    rd_data[B_IND +: 2]       = ind_q;
    rd_data[B_CHG +: N_CHG]   = chg;
    rd_data[B_CAS]            = cas_q;
    rd_data[B_WAKE +: 3]      = wake_q;
    rd_data[B_WARM]           = warm_q;
  end

  assign port_reset_req = rst_q;
  assign warm_reset_req = warm_q;
  assign link_wr_req    = lwr_q;
  assign link_wr_state  = lst_q;

  logic unused_wr_bits;
  assign unused_wr_bits = &{1'b0, wr_data[0], wr_data[3:2], wr_data[13:10], wr_data[24], wr_data[30:28]};

  assert_reset_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_done && port_reset_req) |=> (!port_reset_req && rd_data[B_CHG + C_RST]));
  assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[B_STRB]) |=> !link_wr_req);
  assert_warm_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_warm_done && warm_reset_req) |=> (!warm_reset_req && !rd_data[B_CAS] && rd_data[B_CHG + C_WARM]));
  assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[B_CHG +: N_CHG] != '0));
  assert_disconnect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_connect |=> !rd_data[B_EN]);
endmodule

// File: tb/usb_root_port_regs_tb.sv
module usb_root_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        hw_connect, hw_overcurrent;
  logic [3:0]  hw_speed, hw_link_state;
  logic        hw_reset_done, hw_warm_done, hw_cold_attach, hw_cfg_err;
  logic        port_reset_req, warm_reset_req, link_wr_req, irq;
  logic [3:0]  link_wr_state;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  usb_root_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hw_connect(hw_connect), .hw_overcurrent(hw_overcurrent), .hw_speed(hw_speed),
    .hw_link_state(hw_link_state), .hw_reset_done(hw_reset_done),
    .hw_warm_done(hw_warm_done), .hw_cold_attach(hw_cold_attach), .hw_cfg_err(hw_cfg_err),
    .port_reset_req(port_reset_req), .warm_reset_req(warm_reset_req),
    .link_wr_req(link_wr_req), .link_wr_state(link_wr_state), .irq(irq)
  );

  typedef struct packed {
    logic        conn;
    logic        oc;
    logic [3:0]  ls;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'h5, 1'b0, 32'h0000_0000, 32'h0002_00A1}, // R6 connect change
    '{1'b1, 1'b0, 4'h5, 1'b1, 32'h0002_0000, 32'h0000_00A1}, // R4 clear
    '{1'b1, 1'b0, 4'h0, 1'b1, 32'h0000_0200, 32'h0000_0201}, // R2 power, R10 no flag
    '{1'b1, 1'b0, 4'h3, 1'b0, 32'h0000_0000, 32'h0000_0261}, // R10 U0->U3 none
    '{1'b1, 1'b0, 4'h0, 1'b0, 32'h0000_0000, 32'h0040_0201}, // R10 U3->U0
    '{1'b1, 1'b0, 4'h0, 1'b1, 32'h0040_0200, 32'h0000_0201}, // R4 clear
    '{1'b1, 1'b1, 4'h0, 1'b0, 32'h0000_0000, 32'h0010_0209}, // R6 over-current
    '{1'b1, 1'b1, 4'h0, 1'b1, 32'h0000_0000, 32'h0010_0009}, // R4 write 0 keeps
    '{1'b1, 1'b1, 4'h6, 1'b0, 32'h0000_0000, 32'h0050_00C9}, // R10 to Inactive
    '{1'b0, 1'b0, 4'h5, 1'b0, 32'h0000_0000, 32'h0052_00A0}, // R6 both drop
    '{1'b0, 1'b0, 4'h5, 1'b1, 32'h00FE_0000, 32'h0000_00A0}  // R4 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    hw_connect = 1'b0; hw_overcurrent = 1'b0; hw_speed = 4'h0; hw_link_state = 4'h5;
    hw_reset_done = 1'b0; hw_warm_done = 1'b0; hw_cold_attach = 1'b0; hw_cfg_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset word", rd_data, 32'h0000_00A0);
    check("R5 reset irq", {31'd0, irq}, 32'd0);
    check("R7 reset req", {30'd0, port_reset_req, warm_reset_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      hw_connect = VECS[i].conn; hw_overcurrent = VECS[i].oc; hw_link_state = VECS[i].ls;
      wr_en = VECS[i].we; wr_data = VECS[i].wdata;
      step();
      wr_en = 1'b0; wr_data = '0;
      check($sformatf("R4/R6/R10 vector %0d", i), rd_data, VECS[i].exp);
      check($sformatf("R5 vector %0d irq", i), {31'd0, irq}, {31'd0, |VECS[i].exp[23:17]});
    end

    // R1 reserved bits read zero
    wr(32'h7001_0004);
    check("R1 reserved", rd_data & 32'h7001_0004, 32'd0);
    // R2 read/write fields
    wr(32'h0E00_C200);
    check("R2 fields", rd_data, 32'h0E00_C2A0);
    // R3 no strobe
    wr(32'h0000_0040);
    check("R3 no strobe req", {31'd0, link_wr_req}, 32'd0);
    check("R3 no strobe ls", {28'd0, rd_data[8:5]}, 32'd5);
    // R3 strobe
    wr(32'h0001_0040);
    check("R3 strobe req", {27'd0, link_wr_req, link_wr_state}, 32'h12);
    check("R3 strobe reads 0", {31'd0, rd_data[16]}, 32'd0);
    step();
    check("R3 one cycle", {31'd0, link_wr_req}, 32'd0);

    // connect, then R7 port reset
    hw_connect = 1'b1; step();
    wr(32'h0002_0000);
    check("R5 irq low", {31'd0, irq}, 32'd0);
    wr(32'h0000_0010);
    check("R7 reset req", {30'd0, port_reset_req, rd_data[4]}, 32'd3);
    hw_reset_done = 1'b1; step(); hw_reset_done = 1'b0;
    check("R7 done", {29'd0, port_reset_req, rd_data[21], rd_data[1]}, 32'd3);
    check("R5 irq high", {31'd0, irq}, 32'd1);
    // R8 disable
    wr(32'h0020_0002);
    check("R8 disable", {29'd0, rd_data[1], rd_data[18], rd_data[21]}, 32'd2);
    wr(32'h0004_0000);
    wr(32'h0000_0002);
    check("R8 disable when off ignored", {30'd0, rd_data[1], rd_data[18]}, 32'd0);
    // R8 disconnect clears enable without enable change
    wr(32'h0000_0010);
    hw_reset_done = 1'b1; step(); hw_reset_done = 1'b0;
    wr(32'h0020_0000);
    check("R8 re-enabled", {31'd0, rd_data[1]}, 32'd1);
    hw_connect = 1'b0; step();
    check("R8 disconnect", {29'd0, rd_data[1], rd_data[18], rd_data[17]}, 32'd1);
    hw_connect = 1'b1; step();
    wr(32'h0002_0000);
    // R7 stray done ignored
    hw_reset_done = 1'b1; step(); hw_reset_done = 1'b0;
    check("R7 stray done", {30'd0, rd_data[21], rd_data[1]}, 32'd0);

    // R9 warm reset and cold attach
    hw_cold_attach = 1'b1; step(); hw_cold_attach = 1'b0;
    check("R9 cold attach", {31'd0, rd_data[24]}, 32'd1);
    wr(32'h8000_0000);
    check("R9 warm req", {30'd0, warm_reset_req, rd_data[31]}, 32'd3);
    hw_warm_done = 1'b1; step(); hw_warm_done = 1'b0;
    check("R9 warm done", {28'd0, warm_reset_req, rd_data[31], rd_data[19], rd_data[24]}, 32'd2);
    wr(32'h0008_0000);

    // R11 and R4 set wins over clear
    wr_en = 1'b1; wr_data = 32'h0080_0000; hw_cfg_err = 1'b1;
    step();
    wr_en = 1'b0; wr_data = '0; hw_cfg_err = 1'b0;
    check("R11/R4 set wins", {31'd0, rd_data[23]}, 32'd1);
    wr(32'h0080_0000);
    check("R4 cleared", {31'd0, rd_data[23]}, 32'd0);

    // R1 speed
    hw_speed = 4'h4; step();
    check("R1 speed", {28'd0, rd_data[13:10]}, 32'd4);

    // R10 resume paths
    hw_link_state = 4'h3; step();
    hw_link_state = 4'hF; step();
    check("R10 U3->Resume", {31'd0, rd_data[22]}, 32'd1);
    wr(32'h0040_0000);
    hw_link_state = 4'h8; step();
    check("R10 Resume->Recovery none", {31'd0, rd_data[22]}, 32'd0);
    hw_link_state = 4'h0; step();
    check("R10 Recovery->U0 after resume", {31'd0, rd_data[22]}, 32'd1);
    wr(32'h0040_0000);
    hw_link_state = 4'h8; step();
    hw_link_state = 4'h0; step();
    check("R10 plain recovery none", {31'd0, rd_data[22]}, 32'd0);
    hw_link_state = 4'h2; step();
    hw_link_state = 4'h0; step();
    check("R10 U2->U0", {31'd0, rd_data[22]}, 32'd1);
    wr(32'h0040_0000);
    hw_link_state = 4'h3; step();
    hw_link_state = 4'h8; step();
    check("R10 U3->Recovery none", {31'd0, rd_data[22]}, 32'd0);
    hw_link_state = 4'h0; step();
    check("R10 U3->Recovery->U0", {31'd0, rd_data[22]}, 32'd1);

    finish_run();
  end
endmodule